// File: doc/BRIEF.md
# Physical Register Consumer Counter

This block guards the source-operand mappings that leave a register renamer. It holds one small saturating counter for each physical register. Whenever a renamed instruction names a physical register as a source, that register's counter goes up; when the register-read stage later reads that physical register for an operand, the block first checks that the counter is above zero and then lowers it. A read that arrives for a register with no outstanding rename-time reference can only come from a corrupted mapping, so it is reported as a fault together with the offending tag.

Two source operands are counted per cycle on the rename side, and two read ports are checked per cycle on the read side. Both sides are plain per-operand valid strobes with no ready signal. The block accepts every event in the cycle it is presented, so it never applies back-pressure and upstream stages never stall on it. Fault and overflow reports are registered and appear one cycle after the event that caused them. A pipeline flush wipes every counter in one cycle.

Top module: `pcc_consumer_tracker`

## Requirements
- R1: After reset, every counter is zero and the fault and overflow outputs are low. A read of any tag after reset, including tags 0 and 63, therefore reports a fault.
- R2: A valid rename source operand raises the counter of the tag it names by one. A later read of that tag passes, and the counters of other tags do not change.
- R3: A valid read whose counter is zero raises that port's fault valid, with that port's fault tag equal to the read tag, in the cycle after the read. The zero counter stays at zero and does not wrap.
- R4: A read that passes lowers its counter by one. After one rename and one read of a tag, a second read of that tag faults.
- R5: The nonzero check uses the counter value from before the current cycle's updates. A rename and a passing read of the same tag in the same cycle leave the count unchanged. A rename and a read of a tag whose count is zero in the same cycle report a fault, and the count becomes one.
- R6: When both rename operands of one cycle name the same tag, its counter rises by two.
- R7: When both read ports read the same tag in one cycle, port 0 is checked first. Port 1 passes only if the counter was at least two, so it passes only if a count remains after port 0. Each passing port lowers the counter by one.
- R8: A counter never exceeds 15. An update that would exceed 15 leaves it at 15 and raises the overflow valid output in the next cycle. The overflow tag is then the rename port 0 tag if that register overflowed, and the port 1 tag otherwise.
- R9: While flush is high, all counters are cleared in that one cycle. Rename and read events in a flush cycle are ignored and produce no fault or overflow report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Pipeline flush, clears all counters |
| ren0_vld_i | input | 1 | Rename source operand 0 valid |
| ren0_tag_i | input | 6 | Rename source operand 0 physical tag |
| ren1_vld_i | input | 1 | Rename source operand 1 valid |
| ren1_tag_i | input | 6 | Rename source operand 1 physical tag |
| rd0_vld_i | input | 1 | Register read port 0 valid |
| rd0_tag_i | input | 6 | Register read port 0 physical tag |
| rd1_vld_i | input | 1 | Register read port 1 valid |
| rd1_tag_i | input | 6 | Register read port 1 physical tag |
| flt0_vld_o | output | 1 | Mapping fault on read port 0 (registered) |
| flt0_tag_o | output | 6 | Tag read by port 0 when it faulted |
| flt1_vld_o | output | 1 | Mapping fault on read port 1 (registered) |
| flt1_tag_o | output | 6 | Tag read by port 1 when it faulted |
| ovf_vld_o | output | 1 | Counter saturation error (registered) |
| ovf_tag_o | output | 6 | Tag whose counter saturated |

## Verification
The assertions check on every cycle that a fault report always traces back to a valid, unflushed read of the reported tag one cycle earlier. They also check that an overflow report traces back to a rename of its tag, that a flush cycle is silent, and that port 1 never passes when port 0 fails on the same tag. The counting itself can only be shown by the bench's scenarios, which use sequences of renames and reads to reveal the hidden counts through when a read starts to fault. These scenarios cover the double increment, same-cycle rename and read, saturation at 15 followed by fifteen passing reads, and the clearing done by flush and reset.

// File: rtl/pcc_pkg.sv
package pcc_pkg;

  // Outcome of one read-port check.
  typedef struct packed {
    logic pass;   // counter nonzero, decrement applies
    logic fault;  // valid read found no outstanding consumer
  } rd_res_t;

  // Width of the per-cycle delta on one counter (0..2 each way).
  localparam int DELTA_W = 2;

endpackage

// File: rtl/pcc_cnt_slice.sv
module pcc_cnt_slice
  import pcc_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int TAG_W = 6,
  parameter int IDX   = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_i,
  input  logic             ren0_vld_i,
  input  logic [TAG_W-1:0] ren0_tag_i,
  input  logic             ren1_vld_i,
  input  logic [TAG_W-1:0] ren1_tag_i,
  input  logic             pass0_i,
  input  logic [TAG_W-1:0] rd0_tag_i,
  input  logic             pass1_i,
  input  logic [TAG_W-1:0] rd1_tag_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  localparam logic [TAG_W-1:0] MY_TAG = TAG_W'(IDX);
  localparam int               SUM_W  = CNT_W + DELTA_W;
  localparam logic [SUM_W-1:0] CNT_MAX = SUM_W'((1 << CNT_W) - 1);

  logic [CNT_W-1:0]   cnt_q;
  logic [DELTA_W-1:0] inc;
  logic [DELTA_W-1:0] dec;
  logic [SUM_W-1:0]   sum;
  logic               sat;

  // Up to two increments from rename (R2, R6), two decrements from read (R4, R7).
  always_comb begin
    inc = DELTA_W'(ren0_vld_i && (ren0_tag_i == MY_TAG))
        + DELTA_W'(ren1_vld_i && (ren1_tag_i == MY_TAG));
    dec = DELTA_W'(pass0_i && (rd0_tag_i == MY_TAG))
        + DELTA_W'(pass1_i && (rd1_tag_i == MY_TAG));
    // dec never exceeds cnt_q because passes require enough count (R3, R7)
    sum = SUM_W'(cnt_q) + SUM_W'(inc) - SUM_W'(dec);
    sat = (sum > CNT_MAX);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush_i) begin
      cnt_q <= '0;                                 // R1, R9
    end else if (sat) begin
      cnt_q <= CNT_MAX[CNT_W-1:0];                 // R8
    end else begin
      cnt_q <= sum[CNT_W-1:0];                     // R5 net update
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = sat && !flush_i;

endmodule

// File: rtl/pcc_read_check.sv
module pcc_read_check
  import pcc_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int TAG_W = 6
) (
  input  logic             flush_i,
  input  logic             rd0_vld_i,
  input  logic [TAG_W-1:0] rd0_tag_i,
  input  logic [CNT_W-1:0] rd0_cnt_i,
  input  logic             rd1_vld_i,
  input  logic [TAG_W-1:0] rd1_tag_i,
  input  logic [CNT_W-1:0] rd1_cnt_i,
  output rd_res_t          res0_o,
  output rd_res_t          res1_o
);
  logic             live0;
  logic             live1;
  logic             same_tag;
  logic [CNT_W:0]   need1;

  always_comb begin
    live0    = rd0_vld_i && !flush_i;
    live1    = rd1_vld_i && !flush_i;
    same_tag = rd0_vld_i && (rd0_tag_i == rd1_tag_i);
    // Port 1 needs one more consumer when port 0 reads the same register (R7).
    need1    = (CNT_W+1)'(1) + (CNT_W+1)'(same_tag);

    res0_o.pass  = live0 && (rd0_cnt_i != '0);              // R3, R5
    res0_o.fault = live0 && (rd0_cnt_i == '0);
    res1_o.pass  = live1 && ({1'b0, rd1_cnt_i} >= need1);
    res1_o.fault = live1 && ({1'b0, rd1_cnt_i} <  need1);
  end

endmodule

// File: rtl/pcc_event_reg.sv
module pcc_event_reg #(
  parameter int TAG_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_i,
  input  logic [TAG_W-1:0] tag_i,
  output logic             ev_o,
  output logic [TAG_W-1:0] tag_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ev_o  <= 1'b0;
      tag_o <= '0;
    end else begin
      ev_o  <= ev_i;
      tag_o <= ev_i ? tag_i : tag_o;
    end
  end
endmodule

// File: rtl/pcc_consumer_tracker.sv
module pcc_consumer_tracker
  import pcc_pkg::*;
#(
  parameter  int NUM_PREGS = 64,
  parameter  int CNT_W     = 4,
  localparam int TAG_W     = $clog2(NUM_PREGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_i,
  input  logic             ren0_vld_i,
  input  logic [TAG_W-1:0] ren0_tag_i,
  input  logic             ren1_vld_i,
  input  logic [TAG_W-1:0] ren1_tag_i,
  input  logic             rd0_vld_i,
  input  logic [TAG_W-1:0] rd0_tag_i,
  input  logic             rd1_vld_i,
  input  logic [TAG_W-1:0] rd1_tag_i,
  output logic             flt0_vld_o,
  output logic [TAG_W-1:0] flt0_tag_o,
  output logic             flt1_vld_o,
  output logic [TAG_W-1:0] flt1_tag_o,
  output logic             ovf_vld_o,
  output logic [TAG_W-1:0] ovf_tag_o
);
  logic [CNT_W-1:0]     cnt   [NUM_PREGS];
  logic [NUM_PREGS-1:0] sat_vec;
  rd_res_t              res0;
  rd_res_t              res1;
  logic [CNT_W-1:0]     rd0_cnt;
  logic [CNT_W-1:0]     rd1_cnt;
  logic                 ovf_any;
  logic [TAG_W-1:0]     ovf_tag;

  // Pre-update counter values feed the check (R5).
  assign rd0_cnt = cnt[rd0_tag_i];
  assign rd1_cnt = cnt[rd1_tag_i];

  pcc_read_check #(.CNT_W(CNT_W), .TAG_W(TAG_W)) chk_i (
    .flush_i   (flush_i),
    .rd0_vld_i (rd0_vld_i),
    .rd0_tag_i (rd0_tag_i),
    .rd0_cnt_i (rd0_cnt),
    .rd1_vld_i (rd1_vld_i),
    .rd1_tag_i (rd1_tag_i),
    .rd1_cnt_i (rd1_cnt),
    .res0_o    (res0),
    .res1_o    (res1)
  );

  for (genvar g = 0; g < NUM_PREGS; g++) begin : g_slice
    pcc_cnt_slice #(.CNT_W(CNT_W), .TAG_W(TAG_W), .IDX(g)) slice_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush_i    (flush_i),
      .ren0_vld_i (ren0_vld_i),
      .ren0_tag_i (ren0_tag_i),
      .ren1_vld_i (ren1_vld_i),
      .ren1_tag_i (ren1_tag_i),
      .pass0_i    (res0.pass),
      .rd0_tag_i  (rd0_tag_i),
      .pass1_i    (res1.pass),
      .rd1_tag_i  (rd1_tag_i),
      .cnt_o      (cnt[g]),
      .ovf_o      (sat_vec[g])
    );
  end

  // Only rename targets can saturate; port 0 tag has priority (R8).
  assign ovf_any = |sat_vec;
  assign ovf_tag = sat_vec[ren0_tag_i] ? ren0_tag_i : ren1_tag_i;

  pcc_event_reg #(.TAG_W(TAG_W)) flt0_reg_i (
    .clk (clk), .rst_n (rst_n), .ev_i (res0.fault), .tag_i (rd0_tag_i),
    .ev_o (flt0_vld_o), .tag_o (flt0_tag_o)
  );

  pcc_event_reg #(.TAG_W(TAG_W)) flt1_reg_i (
    .clk (clk), .rst_n (rst_n), .ev_i (res1.fault), .tag_i (rd1_tag_i),
    .ev_o (flt1_vld_o), .tag_o (flt1_tag_o)
  );

  pcc_event_reg #(.TAG_W(TAG_W)) ovf_reg_i (
    .clk (clk), .rst_n (rst_n), .ev_i (ovf_any), .tag_i (ovf_tag),
    .ev_o (ovf_vld_o), .tag_o (ovf_tag_o)
  );

endmodule

// File: rtl/pcc_consumer_tracker_sva.sv
module pcc_consumer_tracker_sva #(
  parameter int TAG_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush_i,
  input logic             ren0_vld_i,
  input logic [TAG_W-1:0] ren0_tag_i,
  input logic             ren1_vld_i,
  input logic [TAG_W-1:0] ren1_tag_i,
  input logic             rd0_vld_i,
  input logic [TAG_W-1:0] rd0_tag_i,
  input logic             rd1_vld_i,
  input logic [TAG_W-1:0] rd1_tag_i,
  input logic             flt0_vld_o,
  input logic [TAG_W-1:0] flt0_tag_o,
  input logic             flt1_vld_o,
  input logic [TAG_W-1:0] flt1_tag_o,
  input logic             ovf_vld_o,
  input logic [TAG_W-1:0] ovf_tag_o
);

  assert_fault0_origin_R3: assert property (@(posedge clk) disable iff (!rst_n)
    flt0_vld_o |-> ($past(rd0_vld_i && !flush_i) && flt0_tag_o == $past(rd0_tag_i)));

  assert_fault1_origin_R3: assert property (@(posedge clk) disable iff (!rst_n)
    flt1_vld_o |-> ($past(rd1_vld_i && !flush_i) && flt1_tag_o == $past(rd1_tag_i)));

  assert_flush_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (!flt0_vld_o && !flt1_vld_o && !ovf_vld_o));

  assert_ovf_origin_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_vld_o |-> ($past(ren0_vld_i || ren1_vld_i) &&
                   (ovf_tag_o == $past(ren0_tag_i) || ovf_tag_o == $past(ren1_tag_i))));

  assert_port_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd0_vld_i && rd1_vld_i && rd0_tag_i == rd1_tag_i && !flush_i)
      |=> (!flt0_vld_o || flt1_vld_o));

endmodule

bind pcc_consumer_tracker pcc_consumer_tracker_sva #(.TAG_W(TAG_W)) sva_i (.*);

// File: tb/pcc_consumer_tracker_tb.sv
`timescale 1ns/1ps
module pcc_consumer_tracker_tb_top;

  localparam int TW = 6;
  localparam int VW = 40;
  localparam int NV = 17;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          flush_i = 1'b0;
  logic          ren0_vld_i = 1'b0, ren1_vld_i = 1'b0;
  logic [TW-1:0] ren0_tag_i = '0, ren1_tag_i = '0;
  logic          rd0_vld_i = 1'b0, rd1_vld_i = 1'b0;
  logic [TW-1:0] rd0_tag_i = '0, rd1_tag_i = '0;
  logic          flt0_vld_o, flt1_vld_o, ovf_vld_o;
  logic [TW-1:0] flt0_tag_o, flt1_tag_o, ovf_tag_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  pcc_consumer_tracker dut_i (
    .clk (clk), .rst_n (rst_n), .flush_i (flush_i),
    .ren0_vld_i (ren0_vld_i), .ren0_tag_i (ren0_tag_i),
    .ren1_vld_i (ren1_vld_i), .ren1_tag_i (ren1_tag_i),
    .rd0_vld_i (rd0_vld_i), .rd0_tag_i (rd0_tag_i),
    .rd1_vld_i (rd1_vld_i), .rd1_tag_i (rd1_tag_i),
    .flt0_vld_o (flt0_vld_o), .flt0_tag_o (flt0_tag_o),
    .flt1_vld_o (flt1_vld_o), .flt1_tag_o (flt1_tag_o),
    .ovf_vld_o (ovf_vld_o), .ovf_tag_o (ovf_tag_o)
  );

  // Vector: [39:36]req [35]flush [34]s0v [33:28]s0t [27]s1v [26:21]s1t
  //         [20]r0v [19:14]r0t [13]r1v [12:7]r1t [6]f0 [5]f1 [4]ovf [3:0]pad
  function automatic logic [VW-1:0] mk(int req, bit fl, bit a, int at, bit b, int bt,
                                       bit c, int ct, bit d, int dt,
                                       bit e0, bit e1, bit eo);
    return {4'(req), fl, a, 6'(at), b, 6'(bt), c, 6'(ct), d, 6'(dt), e0, e1, eo, 4'd0};
  endfunction

  localparam logic [VW-1:0] TBL [NV] = '{
    mk(2, 0, 1, 5, 0, 0,  0, 0, 0, 0,   0, 0, 0),  // R2 rename 5
    mk(2, 0, 0, 0, 0, 0,  1, 5, 0, 0,   0, 0, 0),  // R2 read passes
    mk(4, 0, 0, 0, 0, 0,  1, 5, 0, 0,   1, 0, 0),  // R4 consumed
    mk(3, 0, 0, 0, 0, 0,  0, 0, 1, 7,   0, 1, 0),  // R3 port1 zero
    mk(6, 0, 1, 9, 1, 9,  0, 0, 0, 0,   0, 0, 0),  // R6 +2
    mk(6, 0, 0, 0, 0, 0,  1, 9, 1, 9,   0, 0, 0),  // R6 both pass
    mk(6, 0, 0, 0, 0, 0,  1, 9, 0, 0,   1, 0, 0),  // R6 now empty
    mk(5, 0, 1, 3, 0, 0,  0, 0, 0, 0,   0, 0, 0),  // R5 count 1
    mk(5, 0, 1, 3, 0, 0,  1, 3, 0, 0,   0, 0, 0),  // R5 inc+dec
    mk(5, 0, 0, 0, 0, 0,  1, 3, 0, 0,   0, 0, 0),  // R5 still 1
    mk(5, 0, 1, 4, 0, 0,  1, 4, 0, 0,   1, 0, 0),  // R5 pre-update zero
    mk(5, 0, 0, 0, 0, 0,  1, 4, 0, 0,   0, 0, 0),  // R5 became 1
    mk(7, 0, 1, 10, 0, 0, 0, 0, 0, 0,   0, 0, 0),  // R7 count 1
    mk(7, 0, 0, 0, 0, 0,  1, 10, 1, 10, 0, 1, 0),  // R7 port1 loses
    mk(7, 0, 0, 0, 0, 0,  1, 10, 0, 0,  1, 0, 0),  // R7 single dec
    mk(2, 0, 1, 20, 1, 21, 1, 21, 0, 0, 1, 0, 0),  // R2 pre-update 21 zero
    mk(2, 0, 0, 0, 0, 0,  1, 20, 1, 21, 0, 0, 0)   // R2 independent tags
  };

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Drives one cycle's inputs at a falling edge, then samples at the next one.
  task automatic step(string req, bit fl, bit a, int at, bit b, int bt,
                      bit c, int ct, bit d, int dt, bit e0, bit e1, bit eo);
    flush_i = fl;
    ren0_vld_i = a; ren0_tag_i = TW'(at);
    ren1_vld_i = b; ren1_tag_i = TW'(bt);
    rd0_vld_i  = c; rd0_tag_i  = TW'(ct);
    rd1_vld_i  = d; rd1_tag_i  = TW'(dt);
    @(negedge clk);
    chk(flt0_vld_o == e0, req, "flt0_vld", int'(flt0_vld_o), int'(e0));
    chk(flt1_vld_o == e1, req, "flt1_vld", int'(flt1_vld_o), int'(e1));
    chk(ovf_vld_o  == eo, req, "ovf_vld",  int'(ovf_vld_o),  int'(eo));
    if (e0) chk(flt0_tag_o == TW'(ct), req, "flt0_tag", int'(flt0_tag_o), ct);
    if (e1) chk(flt1_tag_o == TW'(dt), req, "flt1_tag", int'(flt1_tag_o), dt);
    if (eo) chk(ovf_tag_o  == TW'(at), req, "ovf_tag",  int'(ovf_tag_o),  at);
  endtask

  task automatic idle();
    step("idle", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs quiet in reset
    chk(!flt0_vld_o && !flt1_vld_o && !ovf_vld_o, "R1", "outputs in reset",
        int'(flt0_vld_o | flt1_vld_o | ovf_vld_o), 0);
    rst_n = 1'b1;
    // R1: all counters start at zero
    step("R1", 0, 0, 0, 0, 0, 1, 0, 1, 63, 1, 1, 0);

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      string rq;
      v  = TBL[i];
      rq = $sformatf("R%0d", int'(v[39:36]));
      step(rq, v[35], v[34], int'(v[33:28]), v[27], int'(v[26:21]),
           v[20], int'(v[19:14]), v[13], int'(v[12:7]), v[6], v[5], v[4]);
    end

    // R3: zero counter does not wrap after a faulting read
    step("R3", 0, 0, 0, 0, 0, 1, 50, 0, 0, 1, 0, 0);
    step("R3", 0, 1, 50, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R3", 0, 0, 0, 0, 0, 1, 50, 0, 0, 0, 0, 0);
    step("R3", 0, 0, 0, 0, 0, 1, 50, 0, 0, 1, 0, 0);

    // R8: saturation at 15
    for (int k = 0; k < 15; k++) step("R8", 0, 1, 33, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R8", 0, 1, 33, 1, 33, 0, 0, 0, 0, 0, 0, 1);
    idle();
    for (int k = 0; k < 15; k++) step("R8", 0, 0, 0, 0, 0, 1, 33, 0, 0, 0, 0, 0);
    step("R8", 0, 0, 0, 0, 0, 1, 33, 0, 0, 1, 0, 0);

    // R9: flush clears counters and ignores same-cycle events
    step("R9", 0, 1, 40, 1, 41, 0, 0, 0, 0, 0, 0, 0);
    step("R9", 0, 1, 40, 1, 41, 0, 0, 0, 0, 0, 0, 0);
    step("R9", 1, 1, 42, 0, 0, 1, 40, 1, 55, 0, 0, 0);
    step("R9", 0, 0, 0, 0, 0, 1, 40, 1, 41, 1, 1, 0);
    step("R9", 0, 0, 0, 0, 0, 1, 42, 0, 0, 1, 0, 0);

    // R1: reset in mid-run clears counters
    step("R1", 0, 1, 60, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    rst_n = 1'b0;
    idle();
    idle();
    rst_n = 1'b1;
    step("R1", 0, 0, 0, 0, 0, 1, 60, 0, 0, 1, 0, 0);
    idle();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule